// File: doc/BRIEF.md
# Hardware Return Stack with Fault Trap

A small LIFO of 16-bit words kept in internal registers that sits next to a CPU core. Data pushes and pulls, and subroutine calls and returns, all move one shared stack pointer. The pointer steps up by one on every accepted push and down by one on every accepted pull. A call stores the program counter value presented on `pc_i`. A return takes the top word back out and tags it as a return address, so the core can load it into its program counter.

The store is only ten words deep. A push into a full stack, or a pull from an empty one, is refused: no entry and no pointer bit changes, and a sticky stack-fault interrupt request is raised instead. This request is the highest-priority interrupt source, and nothing else sets it. A handler outside this block can then copy words out to main memory and clear the stack. In that way the internal registers act as a cache on top of a larger stack held in memory.

Top module: `hw_stack`

## Requirements
- R1: After synchronous reset, `empty_o`=1, `full_o`=0, `fault_irq_o`=0 and `pop_valid_o`=0.
- R2: An accepted push stores its word. Each accepted pull returns the most recently stored word that has not yet been pulled, on `pop_data_o` with `pop_valid_o`=1, exactly one cycle after the pull strobe. Each push raises the pointer by one and each pull lowers it by one.
- R3: The stack holds exactly DEPTH (default 10) words. `full_o` is 1 only when DEPTH words are held, and `empty_o` is 1 only when none are held. Both follow the pointer in the same cycle it changes.
- R4: `call_i` pushes `pc_i`. `ret_i` pulls the top word, which appears one cycle later with `pop_valid_o`=1 and `pop_is_ret_o`=1. A plain pull gives `pop_is_ret_o`=0.
- R5: A push or call while full sets `fault_irq_o` on the next cycle. The pointer and all stored words stay unchanged.
- R6: A pull or return while empty sets `fault_irq_o` on the next cycle and produces no `pop_valid_o`. The stack stays empty.
- R7: `fault_irq_o` stays 1 until a cycle with `fault_ack_i`=1. If a new fault arrives in the same cycle as the acknowledge, the request stays set.
- R8: `clear_i` empties the stack and drops `fault_irq_o` on the next cycle. It overrides any push, pull, call or return in the same cycle, and none of those can raise a fault in that cycle.
- R9: If a push-type strobe (`push_i` or `call_i`) and a pull-type strobe (`pull_i` or `ret_i`) arrive together, only the push is performed. If `call_i` and `push_i` arrive together, `pc_i` is the word stored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| push_i | input | 1 | Push `wdata_i` |
| pull_i | input | 1 | Pull top word as data |
| call_i | input | 1 | Subroutine call: push `pc_i` |
| ret_i | input | 1 | Return: pull top word as return address |
| wdata_i | input | DATA_W | Data word for a push |
| pc_i | input | DATA_W | Program counter for a call |
| clear_i | input | 1 | Empty the stack and drop the fault request |
| fault_ack_i | input | 1 | Acknowledge the stack-fault request |
| pop_data_o | output | DATA_W | Word taken off the stack |
| pop_valid_o | output | 1 | `pop_data_o` valid this cycle |
| pop_is_ret_o | output | 1 | The popped word came from a return |
| full_o | output | 1 | DEPTH words held |
| empty_o | output | 1 | No words held |
| fault_irq_o | output | 1 | Sticky stack-fault interrupt request |

## Verification
A pointer that slips by one shows up at the ports within a cycle, as `full_o` or `empty_o` at the wrong count. It also shows up on the first later pull, which returns the neighbouring word instead of the expected one. A refused push that still writes does not show until the stack has been drained back down to that slot. For this reason the overflow tests pull all ten words after the fault. A lost or late fault is seen on `fault_irq_o` one cycle after the offending strobe, and it must then stay set across idle cycles.

// File: rtl/stk_pkg.sv
package stk_pkg;
  typedef enum logic [1:0] {
    STK_IDLE = 2'd0,
    STK_PUSH = 2'd1,
    STK_PULL = 2'd2
  } stk_op_e;
endpackage

// File: rtl/stk_ptr.sv
module stk_ptr #(
  parameter int DEPTH = 10,
  parameter int PTR_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clr,
  input  logic             inc,
  input  logic             dec,
  output logic [PTR_W-1:0] level,
  output logic             full,
  output logic             empty
);
  localparam logic [PTR_W-1:0] TOP = PTR_W'(DEPTH);

  always_ff @(posedge clk) begin
    if (rst || clr)
      level <= '0;
    else if (inc)
      level <= level + 1'b1;
    else if (dec)
      level <= level - 1'b1;
  end

  assign full  = (level == TOP);
  assign empty = (level == '0);
endmodule

// File: rtl/stk_mem.sv
module stk_mem #(
  parameter int DATA_W = 16,
  parameter int DEPTH  = 10,
  parameter int AW     = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              we,
  input  logic [AW-1:0]     waddr,
  input  logic [DATA_W-1:0] wdata,
  input  logic              re,
  input  logic [AW-1:0]     raddr,
  output logic [DATA_W-1:0] rdata
);
  logic [DATA_W-1:0] cells [DEPTH];

  always_ff @(posedge clk) begin
    if (we)
      cells[waddr] <= wdata;
  end

  always_ff @(posedge clk) begin
    if (re)
      rdata <= cells[raddr];
  end
endmodule

// File: rtl/stk_fault.sv
module stk_fault (
  input  logic clk,
  input  logic rst,
  input  logic clr,
  input  logic set,
  input  logic ack,
  output logic irq
);
  always_ff @(posedge clk) begin
    if (rst || clr)
      irq <= 1'b0;
    else if (set)
      irq <= 1'b1;
    else if (ack)
      irq <= 1'b0;
  end
endmodule

// File: rtl/hw_stack.sv
module hw_stack
  import stk_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int DEPTH  = 10
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              push_i,
  input  logic              pull_i,
  input  logic              call_i,
  input  logic              ret_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic [DATA_W-1:0] pc_i,
  input  logic              clear_i,
  input  logic              fault_ack_i,
  output logic [DATA_W-1:0] pop_data_o,
  output logic              pop_valid_o,
  output logic              pop_is_ret_o,
  output logic              full_o,
  output logic              empty_o,
  output logic              fault_irq_o
);
  localparam int PTR_W = $clog2(DEPTH + 1);
  localparam int AW    = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [PTR_W-1:0] level;
  logic [PTR_W-1:0] level_m1;
  logic             is_full, is_empty;
  stk_op_e          op;
  logic             want_push, want_pull;
  logic             do_push, do_pull, fault_set;
  logic [DATA_W-1:0] push_word;

  // Arbitration: clear beats everything, push-type beats pull-type.
  always_comb begin
    want_push = push_i | call_i;
    want_pull = (pull_i | ret_i) & ~want_push;
    if (clear_i)        op = STK_IDLE;
    else if (want_push) op = STK_PUSH;
    else if (want_pull) op = STK_PULL;
    else                op = STK_IDLE;
    do_push   = (op == STK_PUSH) & ~is_full;
    do_pull   = (op == STK_PULL) & ~is_empty;
    fault_set = ((op == STK_PUSH) & is_full) | ((op == STK_PULL) & is_empty);
    push_word = call_i ? pc_i : wdata_i;
    level_m1  = level - 1'b1;
  end

  stk_ptr #(.DEPTH(DEPTH), .PTR_W(PTR_W)) u_ptr (
    .clk   (clk),
    .rst   (rst),
    .clr   (clear_i),
    .inc   (do_push),
    .dec   (do_pull),
    .level (level),
    .full  (is_full),
    .empty (is_empty)
  );

  stk_mem #(.DATA_W(DATA_W), .DEPTH(DEPTH), .AW(AW)) u_mem (
    .clk   (clk),
    .we    (do_push),
    .waddr (level[AW-1:0]),
    .wdata (push_word),
    .re    (do_pull),
    .raddr (level_m1[AW-1:0]),
    .rdata (pop_data_o)
  );

  stk_fault u_fault (
    .clk (clk),
    .rst (rst),
    .clr (clear_i),
    .set (fault_set),
    .ack (fault_ack_i),
    .irq (fault_irq_o)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      pop_valid_o  <= 1'b0;
      pop_is_ret_o <= 1'b0;
    end else begin
      pop_valid_o  <= do_pull;
      pop_is_ret_o <= do_pull & ret_i & ~pull_i;
    end
  end

  assign full_o  = is_full;
  assign empty_o = is_empty;
endmodule

// File: rtl/hw_stack_chk.sv
module hw_stack_chk #(
  parameter int DEPTH = 10,
  parameter int PTR_W = $clog2(DEPTH + 1)
) (
  input logic             clk,
  input logic             rst,
  input logic             push_i,
  input logic             pull_i,
  input logic             call_i,
  input logic             ret_i,
  input logic             clear_i,
  input logic             fault_ack_i,
  input logic             pop_valid_o,
  input logic             pop_is_ret_o,
  input logic             full_o,
  input logic             empty_o,
  input logic             fault_irq_o,
  input logic [PTR_W-1:0] level
);
  logic pushy, pully;
  assign pushy = push_i | call_i;
  assign pully = pull_i | ret_i;

  p_flags_excl_r3: assert property (@(posedge clk) disable iff (rst)
    !(full_o && empty_o));

  p_level_step_r2: assert property (@(posedge clk) disable iff (rst)
    (!clear_i && pushy && !full_o) |=> (level == PTR_W'($past(level) + 1)));

  p_no_overflow_r5: assert property (@(posedge clk) disable iff (rst)
    (!clear_i && pushy && full_o) |=> ($stable(level) && fault_irq_o));

  p_no_underflow_r6: assert property (@(posedge clk) disable iff (rst)
    (!clear_i && !pushy && pully && empty_o) |=> (!pop_valid_o && empty_o && fault_irq_o));

  p_fault_hold_r7: assert property (@(posedge clk) disable iff (rst)
    (fault_irq_o && !fault_ack_i && !clear_i) |=> fault_irq_o);

  p_fault_cause_r5: assert property (@(posedge clk) disable iff (rst)
    $rose(fault_irq_o) |-> $past(!clear_i && ((pushy && full_o) || (!pushy && pully && empty_o))));

  p_clear_r8: assert property (@(posedge clk) disable iff (rst)
    clear_i |=> (empty_o && !fault_irq_o));

  p_ret_tag_r4: assert property (@(posedge clk) disable iff (rst)
    pop_is_ret_o |-> pop_valid_o);

  p_push_wins_r9: assert property (@(posedge clk) disable iff (rst)
    (!clear_i && pushy && pully) |=> !pop_valid_o);
endmodule

bind hw_stack hw_stack_chk #(.DEPTH(DEPTH), .PTR_W(PTR_W)) u_chk (
  .clk          (clk),
  .rst          (rst),
  .push_i       (push_i),
  .pull_i       (pull_i),
  .call_i       (call_i),
  .ret_i        (ret_i),
  .clear_i      (clear_i),
  .fault_ack_i  (fault_ack_i),
  .pop_valid_o  (pop_valid_o),
  .pop_is_ret_o (pop_is_ret_o),
  .full_o       (full_o),
  .empty_o      (empty_o),
  .fault_irq_o  (fault_irq_o),
  .level        (level)
);

// File: tb/tb_hw_stack.sv
module tb_hw_stack;
  localparam int CLK_PERIOD = 10;
  localparam int DW = 16;
  localparam int DEPTH = 10;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic push_i = 0, pull_i = 0, call_i = 0, ret_i = 0, clear_i = 0, fault_ack_i = 0;
  logic [DW-1:0] wdata_i = '0, pc_i = '0;
  logic [DW-1:0] pop_data_o;
  logic pop_valid_o, pop_is_ret_o, full_o, empty_o, fault_irq_o;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  hw_stack #(.DATA_W(DW), .DEPTH(DEPTH)) dut (
    .clk(clk), .rst(rst), .push_i(push_i), .pull_i(pull_i), .call_i(call_i),
    .ret_i(ret_i), .wdata_i(wdata_i), .pc_i(pc_i), .clear_i(clear_i),
    .fault_ack_i(fault_ack_i), .pop_data_o(pop_data_o), .pop_valid_o(pop_valid_o),
    .pop_is_ret_o(pop_is_ret_o), .full_o(full_o), .empty_o(empty_o),
    .fault_irq_o(fault_irq_o)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  task automatic idle();
    @(negedge clk);
  endtask

  task automatic push_word(input logic [DW-1:0] v);
    wdata_i = v; push_i = 1;
    @(negedge clk);
    push_i = 0;
  endtask

  task automatic pull_expect(input logic [DW-1:0] v, input bit as_ret, input string req);
    if (as_ret) ret_i = 1; else pull_i = 1;
    @(negedge clk);
    ret_i = 0; pull_i = 0;
    chk(pop_valid_o == 1'b1, req, int'(pop_valid_o), 1);
    chk(pop_data_o == v, req, int'(pop_data_o), int'(v));
    chk(pop_is_ret_o == as_ret, req, int'(pop_is_ret_o), int'(as_ret));
  endtask

  task automatic ack();
    fault_ack_i = 1;
    @(negedge clk);
    fault_ack_i = 0;
  endtask

  task automatic t_reset();
    chk(empty_o == 1, "R1 empty", int'(empty_o), 1);
    chk(full_o == 0, "R1 full", int'(full_o), 0);
    chk(fault_irq_o == 0, "R1 irq", int'(fault_irq_o), 0);
    chk(pop_valid_o == 0, "R1 valid", int'(pop_valid_o), 0);
  endtask

  task automatic t_lifo();
    push_word(16'hA001);
    chk(empty_o == 0, "R3 not empty after push", int'(empty_o), 0);
    push_word(16'hA002);
    push_word(16'hA003);
    pull_expect(16'hA003, 0, "R2 lifo top");
    push_word(16'hA004);
    pull_expect(16'hA004, 0, "R2 lifo interleave");
    pull_expect(16'hA002, 0, "R2 lifo mid");
    pull_expect(16'hA001, 0, "R2 lifo bottom");
    chk(empty_o == 1, "R2 empty after drain", int'(empty_o), 1);
  endtask

  task automatic t_overflow();
    for (int i = 0; i < DEPTH; i++) begin
      chk(full_o == 0, "R3 not full early", int'(full_o), 0);
      push_word(DW'(16'h1000 + i));
    end
    chk(full_o == 1, "R3 full at depth", int'(full_o), 1);
    push_word(16'hDEAD);
    chk(fault_irq_o == 1, "R5 irq on overflow", int'(fault_irq_o), 1);
    chk(full_o == 1, "R5 still full", int'(full_o), 1);
    pc_i = 16'hBEEF; call_i = 1; fault_ack_i = 1;
    @(negedge clk);
    call_i = 0; fault_ack_i = 0;
    chk(fault_irq_o == 1, "R7 fault beats ack", int'(fault_irq_o), 1);
    for (int k = 0; k < 4; k++) idle();
    chk(fault_irq_o == 1, "R7 irq sticky", int'(fault_irq_o), 1);
    ack();
    chk(fault_irq_o == 0, "R7 ack clears", int'(fault_irq_o), 0);
    for (int i = DEPTH - 1; i >= 0; i--)
      pull_expect(DW'(16'h1000 + i), 0, "R5 entries intact");
    chk(empty_o == 1, "R3 empty after ten pulls", int'(empty_o), 1);
  endtask

  task automatic t_underflow();
    pull_i = 1;
    @(negedge clk);
    pull_i = 0;
    chk(fault_irq_o == 1, "R6 irq on underflow", int'(fault_irq_o), 1);
    chk(pop_valid_o == 0, "R6 no valid", int'(pop_valid_o), 0);
    chk(empty_o == 1, "R6 still empty", int'(empty_o), 1);
    ack();
    ret_i = 1;
    @(negedge clk);
    ret_i = 0;
    chk(fault_irq_o == 1, "R6 irq on empty return", int'(fault_irq_o), 1);
    ack();
    push_word(16'h0077);
    pull_expect(16'h0077, 0, "R6 pointer unchanged");
  endtask

  task automatic t_call_ret();
    push_word(16'h5555);
    pc_i = 16'h0123; call_i = 1;
    @(negedge clk);
    call_i = 0;
    pc_i = 16'h0456; call_i = 1;
    @(negedge clk);
    call_i = 0;
    pull_expect(16'h0456, 1, "R4 return tagged");
    pull_expect(16'h0123, 1, "R4 return nested");
    pull_expect(16'h5555, 0, "R4 plain pull untagged");
  endtask

  task automatic t_clear();
    push_word(16'h0001);
    push_word(16'h0002);
    clear_i = 1; push_i = 1; wdata_i = 16'h0003;
    @(negedge clk);
    clear_i = 0; push_i = 0;
    chk(empty_o == 1, "R8 clear empties", int'(empty_o), 1);
    pull_i = 1;
    @(negedge clk);
    pull_i = 0;
    chk(fault_irq_o == 1, "R8 setup fault", int'(fault_irq_o), 1);
    clear_i = 1; pull_i = 1;
    @(negedge clk);
    clear_i = 0; pull_i = 0;
    chk(fault_irq_o == 0, "R8 clear drops irq", int'(fault_irq_o), 0);
    chk(pop_valid_o == 0, "R8 pull ignored", int'(pop_valid_o), 0);
  endtask

  task automatic t_priority();
    push_word(16'h0A0A);
    push_i = 1; pull_i = 1; wdata_i = 16'h0B0B;
    @(negedge clk);
    push_i = 0; pull_i = 0;
    chk(pop_valid_o == 0, "R9 pull suppressed", int'(pop_valid_o), 0);
    push_i = 1; call_i = 1; wdata_i = 16'h0C0C; pc_i = 16'h0D0D;
    @(negedge clk);
    push_i = 0; call_i = 0;
    pull_expect(16'h0D0D, 0, "R9 call word wins");
    pull_expect(16'h0B0B, 0, "R9 push performed");
    pull_expect(16'h0A0A, 0, "R9 bottom kept");
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    chk(0, "watchdog", 0, 1);
    summary();
  end

  initial begin
    @(negedge clk);
    @(negedge clk);
    rst = 0;
    t_reset();
    t_lifo();
    t_overflow();
    t_underflow();
    t_call_ret();
    t_clear();
    t_priority();
    idle();
    summary();
  end
endmodule